// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs single read and write cycles on an external memory bus for one internal requester. A request is taken together with its own bus settings: the bus shape (address and data on a shared port or on separate ports, 8-bit or 16-bit data) and the timing of every phase. The timing settings are the address-latch pulse length, a one-cycle strobe delay, the number of data-phase wait states, an optional ready handshake and an optional recovery cycle after reads. The block returns a one-cycle acknowledge and, for reads, the data that was collected.

The state machine has six states. IDLE takes a request (IDLE→ADDR). ADDR raises the latch pulse for one cycle, or two when lengthened (ADDR→ADDR once). When the strobe delay is on, ADDR goes to GAP (GAP→DATA), and otherwise it goes straight to DATA. DATA holds the read or write strobe low until the wait count has run out and, when the handshake is on, until ready is seen. From DATA the machine goes to RECOV after a read with recovery on, or back to ADDR for the high byte of a split access, or to DONE. RECOV goes to ADDR for a pending high byte and to DONE otherwise. DONE raises the acknowledge and returns to IDLE.

A 16-bit access on an 8-bit bus is split into two byte cycles: the low byte at the given address first, then the high byte at the address plus one. The acknowledge is raised once, after the second cycle.

Top module: `ext_bus_seq`

## Requirements
- R1: During and straight after reset: bus_ale=0, bus_rd_n=1, bus_wr_n=1, bus_ad_oe=0, ack=0.
- R2: bus_ale is high for 1 cycle per byte cycle, or 2 cycles when cfg_ale_long=1. While it is high, neither strobe is low.
- R3: With cfg_strobe_dly=1, one cycle with no latch and no strobe comes between the latch pulse and the strobe. With cfg_strobe_dly=0 the strobe follows the latch pulse directly.
- R4: With cfg_rdy_en=0, the strobe stays low for exactly cfg_waits+1 cycles per byte cycle.
- R5: With cfg_rdy_en=1, the strobe stays low until the first cycle in which both the wait count has run out and bus_rdy=1 is sampled. If ready is first seen in cycle K of the strobe (counted from 0), the strobe lasts max(cfg_waits,K)+1 cycles.
- R6: A read with cfg_recov=1 adds one idle cycle after the strobe. The setting has no effect on writes.
- R7: In multiplexed mode (cfg_mux=1) the data port is driven with the low 16 address bits while bus_ale is high. In demultiplexed mode it is released then. bus_addr carries the byte-cycle address during the whole cycle and stays stable while a strobe is low.
- R8: The data port is driven during a write strobe and never during a read strobe. On a 16-bit bus it carries req_wdata. On an 8-bit bus (cfg_bus8=1) it carries the current byte in bits 7:0 with bits 15:8 zero.
- R9: A read on a 16-bit bus returns all of bus_ad_i. On an 8-bit bus, req_word=1 runs two byte cycles (low byte from address A, high byte from A+1) and req_word=0 runs one, with rdata[15:8]=0.
- R10: The acknowledge lasts one cycle and comes 1 + the sum of the byte-cycle lengths after the request is taken. bus_rd_n and bus_wr_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access (8-bit bus) |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| cfg_mux | input | 1 | 1 = shared address/data port |
| cfg_bus8 | input | 1 | 1 = 8-bit external data |
| cfg_waits | input | WAIT_W | Data-phase wait states |
| cfg_ale_long | input | 1 | Lengthened latch pulse |
| cfg_strobe_dly | input | 1 | One-cycle gap before the strobe |
| cfg_recov | input | 1 | Recovery cycle after reads |
| cfg_rdy_en | input | 1 | Use the ready handshake |
| ack | output | 1 | Access complete, one cycle |
| rdata | output | DW | Read result |
| bus_addr | output | AW | External address port |
| bus_ad_o | output | DW | Data/address port, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| bus_ad_i | input | DW | Data/address port, incoming value |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rdy | input | 1 | External ready, active high |

## Verification
The wait-state count and the ready handshake both decide when the strobe ends, and they can settle in the same cycle. The bench's memory model raises ready in the fourth strobe cycle. The wait counts swept are below, equal to and above that point, so ready arrives before, exactly when and after the count runs out. Each access is judged by its measured strobe width against max(waits, 3)+1 and by its acknowledge latency. A second case is the recovery cycle of a low-byte read falling just before the next latch pulse of a split access; the latency sum covers it.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_GAP,
        S_DATA,
        S_RECOV,
        S_DONE
    } bus_state_e;

    // settings captured at the start of an access
    typedef struct packed {
        logic mux;
        logic bus8;
        logic ale_long;
        logic strobe_dly;
        logic recov;
        logic rdy_en;
        logic we;
        logic split;     // two byte cycles
    } bus_cfg_t;

endpackage

// File: rtl/ext_bus_fsm.sv
module ext_bus_fsm
    import ext_bus_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  bus_cfg_t          cfg_in,
    input  logic [WAIT_W-1:0] waits_in,
    input  logic              bus_rdy,
    output bus_state_e        st,
    output logic              byte_hi,
    output logic              accept,
    output logic              capture,
    output logic              bus8_q,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              oe_addr,
    output logic              oe_data,
    output logic              ack
);
    localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

    bus_state_e        st_nx;
    bus_cfg_t          cfg_q;
    logic [WAIT_W-1:0] waits_q;
    logic [WAIT_W-1:0] cnt;
    logic              ale_ext;
    logic              data_end;
    logic              more;

    assign accept   = (st == S_IDLE) && req;
    assign data_end = (cnt >= waits_q) && (!cfg_q.rdy_en || bus_rdy);
    assign more     = cfg_q.split && !byte_hi;
    assign capture  = (st == S_DATA) && data_end && !cfg_q.we;
    assign bus8_q   = cfg_q.bus8;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (req) st_nx = S_ADDR;
            S_ADDR:  if (!cfg_q.ale_long || ale_ext)
                         st_nx = cfg_q.strobe_dly ? S_GAP : S_DATA;
            S_GAP:   st_nx = S_DATA;
            S_DATA:  if (data_end) begin
                         if (!cfg_q.we && cfg_q.recov) st_nx = S_RECOV;
                         else if (more)                st_nx = S_ADDR;
                         else                          st_nx = S_DONE;
                     end
            S_RECOV: st_nx = more ? S_ADDR : S_DONE;
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // captured settings, phase counters, byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            waits_q <= '0;
            cnt     <= '0;
            ale_ext <= 1'b0;
            byte_hi <= 1'b0;
        end else begin
            if (accept) begin
                cfg_q   <= cfg_in;
                waits_q <= waits_in;
                byte_hi <= 1'b0;
            end else if (st_nx == S_ADDR && st != S_ADDR) begin
                byte_hi <= 1'b1;
            end
            ale_ext <= (st == S_ADDR);
            if (st == S_DATA && st_nx == S_DATA)
                cnt <= (cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
            else
                cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        ale     = (st == S_ADDR);
        rd_n    = !((st == S_DATA) && !cfg_q.we);
        wr_n    = !((st == S_DATA) &&  cfg_q.we);
        oe_addr = (st == S_ADDR) && cfg_q.mux;
        oe_data = (st == S_DATA) && cfg_q.we;
        ack     = (st == S_DONE);
    end

endmodule

// File: rtl/ext_bus_dpath.sv
module ext_bus_dpath #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          byte_hi,
    input  logic          bus8,
    input  logic          busy,
    input  logic          oe_addr,
    input  logic          oe_data,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_ad_i,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_ad_oe,
    output logic [DW-1:0] rdata
);
    localparam int BW = DW / 2;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] wbeat;

    assign cur_addr = addr_q + AW'(byte_hi);
    assign wbeat    = bus8 ? {{BW{1'b0}}, (byte_hi ? wdata_q[DW-1:BW] : wdata_q[BW-1:0])}
                           : wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                if (!bus8)        rdata           <= bus_ad_i;
                else if (byte_hi) rdata[DW-1:BW]  <= bus_ad_i[BW-1:0];
                else              rdata           <= {{BW{1'b0}}, bus_ad_i[BW-1:0]};
            end
        end
    end

    always_comb begin
        bus_addr  = busy ? cur_addr : '0;
        bus_ad_oe = oe_addr || oe_data;
        if (oe_addr)      bus_ad_o = cur_addr[DW-1:0];
        else if (oe_data) bus_ad_o = wbeat;
        else              bus_ad_o = '0;
    end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_pkg::*;
#(
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic              req_word,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              cfg_mux,
    input  logic              cfg_bus8,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic              cfg_ale_long,
    input  logic              cfg_strobe_dly,
    input  logic              cfg_recov,
    input  logic              cfg_rdy_en,
    output logic              ack,
    output logic [DW-1:0]     rdata,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [DW-1:0]     bus_ad_i,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    input  logic              bus_rdy
);
    bus_cfg_t   cfg_in;
    bus_state_e st;
    logic       byte_hi, accept, capture, bus8_q, oe_addr, oe_data;

    always_comb begin
        cfg_in.mux        = cfg_mux;
        cfg_in.bus8       = cfg_bus8;
        cfg_in.ale_long   = cfg_ale_long;
        cfg_in.strobe_dly = cfg_strobe_dly;
        cfg_in.recov      = cfg_recov;
        cfg_in.rdy_en     = cfg_rdy_en;
        cfg_in.we         = req_we;
        cfg_in.split      = cfg_bus8 && req_word;
    end

    ext_bus_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .cfg_in   (cfg_in),
        .waits_in (cfg_waits),
        .bus_rdy  (bus_rdy),
        .st       (st),
        .byte_hi  (byte_hi),
        .accept   (accept),
        .capture  (capture),
        .bus8_q   (bus8_q),
        .ale      (bus_ale),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .oe_addr  (oe_addr),
        .oe_data  (oe_data),
        .ack      (ack)
    );

    ext_bus_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .byte_hi   (byte_hi),
        .bus8      (bus8_q),
        .busy      (st != S_IDLE),
        .oe_addr   (oe_addr),
        .oe_data   (oe_data),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_ad_i  (bus_ad_i),
        .bus_addr  (bus_addr),
        .bus_ad_o  (bus_ad_o),
        .bus_ad_oe (bus_ad_oe),
        .rdata     (rdata)
    );

endmodule

// File: rtl/ext_bus_chk.sv
module ext_bus_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          bus_ale,
    input logic          bus_rd_n,
    input logic          bus_wr_n,
    input logic          bus_ad_oe,
    input logic [AW-1:0] bus_addr
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_no_drive_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);

    assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n));

    assert_ale_max_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && $past(bus_ale)) |=> !bus_ale);

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_rd_n && bus_wr_n) && $past(!(bus_rd_n && bus_wr_n))) |-> $stable(bus_addr));

endmodule

bind ext_bus_seq ext_bus_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .bus_ale   (bus_ale),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_ad_oe (bus_ad_oe),
    .bus_addr  (bus_addr)
);

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;
    localparam int AW = 24, DW = 16, WAIT_W = 4, RDY_AT = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 0, req_we = 0, req_word = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic cfg_mux = 0, cfg_bus8 = 0, cfg_ale_long = 0, cfg_strobe_dly = 0, cfg_recov = 0, cfg_rdy_en = 0;
    logic [WAIT_W-1:0] cfg_waits = '0;
    logic ack, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n, bus_rdy;
    logic [DW-1:0] rdata, bus_ad_o, bus_ad_i;
    logic [AW-1:0] bus_addr;
    logic [3:0] scnt = '0;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    ext_bus_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) u_ext_bus_seq (.*);

    // memory model: data from address, ready from the fourth strobe cycle on
    assign bus_ad_i = {bus_addr[7:0] ^ 8'hA5, bus_addr[7:0] ^ 8'h3C};
    assign bus_rdy  = (scnt >= RDY_AT);
    always_ff @(posedge clk) scnt <= (!bus_rd_n || !bus_wr_n) ? scnt + 4'd1 : 4'd0;

    function automatic logic [DW-1:0] mw(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input bit we, input bit word, input bit mux, input bit b8,
                       input int w, input bit al, input bit dl, input bit tr, input bit re,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int n = 0, nb = 0, alec = 0, strc = 0, bad = 0, d, len, exp_nb, exp_lat;
        logic [DW-1:0] wcap [2];
        bit prev_ale = 0;
        wcap[0] = '0; wcap[1] = '0;
        @(negedge clk);
        req = 1; req_we = we; req_word = word; req_addr = a; req_wdata = wd;
        cfg_mux = mux; cfg_bus8 = b8; cfg_waits = WAIT_W'(w); cfg_ale_long = al;
        cfg_strobe_dly = dl; cfg_recov = tr; cfg_rdy_en = re;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (bus_ale) begin
                alec++;
                if (!prev_ale) nb++;
                if (bus_addr != a + AW'(nb - 1)) bad++;
                if (mux && (!bus_ad_oe || bus_ad_o != DW'(a + AW'(nb - 1)))) bad++;
                if (!mux && bus_ad_oe) bad++;
            end
            prev_ale = bus_ale;
            if (!bus_rd_n || !bus_wr_n) strc++;
            if (!bus_wr_n && nb >= 1 && nb <= 2) wcap[nb-1] = bus_ad_oe ? bus_ad_o : 'x;
            if (ack || n > 120) break;
        end
        req = 0;
        exp_nb  = (b8 && word) ? 2 : 1;
        d       = re ? ((w > RDY_AT) ? w : RDY_AT) : w;
        len     = 1 + al + dl + d + 1 + ((!we && tr) ? 1 : 0);
        exp_lat = 1 + exp_nb * len;
        chk(n == exp_lat, tr ? "R6 latency" : (dl ? "R3 latency" : "R10 latency"), n, exp_lat);
        chk(nb == exp_nb, "R9 byte cycles", nb, exp_nb);
        chk(alec == exp_nb * (1 + al), "R2 latch width", alec, exp_nb * (1 + al));
        chk(strc == exp_nb * (d + 1), re ? "R5 strobe width" : "R4 strobe width", strc, exp_nb * (d + 1));
        chk(bad == 0, "R7 address phase", bad, 0);
        if (we) begin
            if (!b8) chk(wcap[0] === wd, "R8 write word", wcap[0], wd);
            else begin
                chk(wcap[0] === {8'h00, wd[7:0]}, "R8 write low byte", wcap[0], {8'h00, wd[7:0]});
                if (word) chk(wcap[1] === {8'h00, wd[15:8]}, "R8 write high byte", wcap[1], {8'h00, wd[15:8]});
            end
        end else begin
            logic [DW-1:0] er;
            if (!b8)      er = mw(a);
            else if (word) er = {mw(a + 1)[7:0], mw(a)[7:0]};
            else           er = {8'h00, mw(a)[7:0]};
            chk(rdata === er, "R9 read data", rdata, er);
        end
        @(negedge clk);
        chk(!ack, "R10 ack one cycle", ack, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !ack, "R1 reset outputs",
            {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, ack}, 5'b01100);
        rst_n = 1;
        @(negedge clk);
        chk(!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !ack, "R1 after reset",
            {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, ack}, 5'b01100);
        for (int m = 0; m < 4; m++)
            for (int we = 0; we < 2; we++)
                for (int wi = 0; wi < 3; wi++)
                    for (int c = 0; c < 16; c++) begin
                        t++;
                        run(we[0], 1'b1, m[0], m[1], (wi == 0) ? 0 : wi + 2,
                            c[0], c[1], c[2], c[3], 24'h12_3400 + AW'(t * 6),
                            16'h9C00 ^ DW'(t * 37));
                    end
        // byte accesses on the 8-bit bus: one cycle, upper read byte zero
        for (int m = 0; m < 2; m++)
            for (int we = 0; we < 2; we++)
                run(we[0], 1'b0, m[0], 1'b1, 1, 1'b0, 1'b1, 1'b1, 1'b0,
                    24'h00_7F10 + AW'(m * 2), 16'hBEEF);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule